// File: doc/BRIEF.md
# Keyed Integer Clock Divider

This block turns one fast source clock into a periodic count-enable for a pulse-width counter. It divides by a 12-bit integer. Software sets it up through two 32-bit registers on a simple memory-mapped bus. The control register is at offset 0x00 and holds the source select, an enable and a read-only busy flag. The divisor register is at offset 0x04. A write lands only when its top byte carries the key value 0x5A. A write with any other top byte is dropped whole.

Busy is the real run state of the divider. It rises once the divider starts. After enable is removed, it stays high until the period in progress is complete, so the counter never sees a shortened period. Software polls busy both when stopping and when starting. While busy is high, the source select and the divisor are frozen, and only the enable can be changed.

Top module: `kclk_div`

## Requirements
- R1: A write to either register whose data bits [31:24] differ from 0x5A changes nothing: the stored fields, busy and clk_en all stay as they were.
- R2: The control register holds the source select in bits [3:0] and the enable in bit 4, and it reports busy in bit 7. Bits 5, 6 and 7 ignore writes and read as 0, except that bit 7 reads as busy.
- R3: The divisor register stores bits [23:12] of a keyed write and reads them back in the same place. Every other bit reads as 0, including bits [31:24] of both registers.
- R4: If enable is 1, the source select is 6 and the divisor is at least 4 at a clock edge where busy is 0, then busy is 1 from the next edge onward. It is therefore still 0 right after the enabling write and is 1 one cycle later.
- R5: The divider never starts while the source select is not 6 or the divisor is below 4.
- R6: While busy, clk_en is a one-cycle pulse that repeats every divisor cycles. The first pulse comes in the cycle that begins divisor-1 edges after the edge where busy rose.
- R7: After enable is cleared, busy falls only on the edge that ends a cycle with clk_en high, and this happens within one divisor period. After that, clk_en stays 0.
- R8: While busy is 1, keyed writes to the divisor or to the source select are dropped, but the enable bit still takes the written value.
- R9: After reset, both registers read 0, and busy and clk_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 3 | Byte offset: 0 = control, 4 = divisor |
| bus_wdata | input | 32 | Write data with the key in [31:24] |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| clk_en | output | 1 | Divided clock enable pulse |
| busy | output | 1 | Divider running flag |

## Verification
A keyed write updates the stored fields on the edge that samples the strobe, and readback is combinational. The bench therefore reads each field at the falling edge just after the write. Busy rises one edge after the enabling write. Counting from the sample where busy is first 1 as index 0, clk_en must be high exactly at indices divisor-1 and 2·divisor-1, and this is checked for divisors 4, 9 and 4095. On a stop, the bench walks one falling edge at a time until busy is 0. It then requires that clk_en was high at the sample before, and that no more than divisor samples have passed.

// File: rtl/kclk_pkg.sv
package kclk_pkg;
   localparam int unsigned DATA_W   = 32;
   localparam int unsigned KEY_LSB  = 24;
   localparam logic [7:0]  KEY_VAL  = 8'h5A;
   localparam int unsigned EN_BIT   = 4;
   localparam int unsigned BUSY_BIT = 7;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_DIV  = 2'd2
   } reg_sel_e;
endpackage

// File: rtl/kclk_regs.sv
module kclk_regs
   import kclk_pkg::*;
#(
   parameter int unsigned ADDR_W   = 3,
   parameter int unsigned SRC_W    = 4,
   parameter int unsigned DIV_W    = 12,
   parameter int unsigned DIV_LSB  = 12,
   parameter int unsigned CTRL_OFF = 0,
   parameter int unsigned DIV_OFF  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              running,
   output logic [SRC_W-1:0]  src_q,
   output logic              en_q,
   output logic [DIV_W-1:0]  div_q,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned DIV_MSB = DIV_LSB + DIV_W - 1;

   generate
      if (SRC_W > EN_BIT) begin : g_bad_src
         $error("source select overlaps enable bit");
      end
      if (DIV_MSB >= KEY_LSB) begin : g_bad_div
         $error("divisor field overlaps key byte");
      end
   endgenerate

   reg_sel_e sel;
   logic     key_ok;

   always_comb begin
      if (addr == ADDR_W'(CTRL_OFF))     sel = SEL_CTRL;
      else if (addr == ADDR_W'(DIV_OFF)) sel = SEL_DIV;
      else                               sel = SEL_NONE;
   end

   assign key_ok = (wdata[DATA_W-1:KEY_LSB] == KEY_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= '0;
         en_q  <= 1'b0;
         div_q <= '0;
      end else if (wr && key_ok) begin
         if (sel == SEL_CTRL) begin
            en_q <= wdata[EN_BIT];
            if (!running) src_q <= wdata[SRC_W-1:0];
         end
         if (sel == SEL_DIV && !running) div_q <= wdata[DIV_MSB:DIV_LSB];
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CTRL: begin
            rdata[SRC_W-1:0] = src_q;
            rdata[EN_BIT]    = en_q;
            rdata[BUSY_BIT]  = running;
         end
         SEL_DIV:  rdata[DIV_MSB:DIV_LSB] = div_q;
         default:  rdata = '0;
      endcase
   end
endmodule

// File: rtl/kclk_core.sv
module kclk_core #(
   parameter int unsigned SRC_W   = 4,
   parameter int unsigned DIV_W   = 12,
   parameter int unsigned SRC_OK  = 6,
   parameter int unsigned MIN_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SRC_W-1:0] src,
   input  logic [DIV_W-1:0] div,
   output logic             running,
   output logic             tick
);
   generate
      if (MIN_DIV < 2) begin : g_bad_min
         $error("minimum divisor must be at least 2");
      end
   endgenerate

   logic [DIV_W-1:0] cnt;
   logic             start_ok;
   logic             last;

   assign start_ok = en && (src == SRC_W'(SRC_OK)) && (div >= DIV_W'(MIN_DIV));
   assign last     = running && (cnt == div - DIV_W'(1));
   assign tick     = last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         cnt     <= '0;
      end else if (!running) begin
         cnt <= '0;
         if (start_ok) running <= 1'b1;
      end else if (last) begin
         cnt <= '0;
         if (!en) running <= 1'b0;
      end else begin
         cnt <= cnt + DIV_W'(1);
      end
   end
endmodule

// File: rtl/kclk_div.sv
module kclk_div #(
   parameter int unsigned ADDR_W  = 3,
   parameter int unsigned SRC_W   = 4,
   parameter int unsigned DIV_W   = 12,
   parameter int unsigned DIV_LSB = 12,
   parameter int unsigned SRC_OK  = 6,
   parameter int unsigned MIN_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              clk_en,
   output logic              busy
);
   logic [SRC_W-1:0] src_q;
   logic             en_q;
   logic [DIV_W-1:0] div_q;

   kclk_regs #(
      .ADDR_W(ADDR_W), .SRC_W(SRC_W), .DIV_W(DIV_W), .DIV_LSB(DIV_LSB),
      .CTRL_OFF(0), .DIV_OFF(4)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .running(busy), .src_q(src_q), .en_q(en_q),
      .div_q(div_q), .rdata(bus_rdata)
   );

   kclk_core #(
      .SRC_W(SRC_W), .DIV_W(DIV_W), .SRC_OK(SRC_OK), .MIN_DIV(MIN_DIV)
   ) u_core (
      .clk(clk), .rst_n(rst_n), .en(en_q), .src(src_q), .div(div_q),
      .running(busy), .tick(clk_en)
   );
endmodule

// File: rtl/kclk_div_chk.sv
module kclk_div_chk #(
   parameter int unsigned SRC_W   = 4,
   parameter int unsigned DIV_W   = 12,
   parameter int unsigned SRC_OK  = 6,
   parameter int unsigned MIN_DIV = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_wr,
   input logic [31:0]      bus_wdata,
   input logic             busy,
   input logic             clk_en,
   input logic             en_q,
   input logic [SRC_W-1:0] src_q,
   input logic [DIV_W-1:0] div_q
);
   logic [DIV_W-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      gap <= '0;
      else if (!busy)  gap <= '0;
      else if (clk_en) gap <= '0;
      else             gap <= gap + DIV_W'(1);
   end

   // R1: unkeyed writes leave all stored fields untouched
   a_r1_unkeyed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_wdata[31:24] != 8'h5A) |=> ($stable(div_q) && $stable(src_q) && $stable(en_q)));

   // R4 and R5: a start needs enable, the right source and a legal divisor
   a_r4_r5_start_cond: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> ($past(en_q) && $past(src_q) == SRC_W'(SRC_OK) && $past(div_q) >= DIV_W'(MIN_DIV)));

   // R6: pulses only while running, spaced by the divisor
   a_r6_tick_in_run: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> busy);
   a_r6_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      clk_en |-> (gap == div_q - DIV_W'(1)));

   // R7: stop only at the end of a full period, and only when disabled
   a_r7_fall_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(clk_en) && !$past(en_q)));

   // R8: divisor and source frozen while running
   a_r8_frozen_fields: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(div_q) && $stable(src_q)));
endmodule

bind kclk_div kclk_div_chk #(
   .SRC_W(SRC_W), .DIV_W(DIV_W), .SRC_OK(SRC_OK), .MIN_DIV(MIN_DIV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
   .busy(busy), .clk_en(clk_en), .en_q(en_q), .src_q(src_q), .div_q(div_q)
);

// File: tb/kclk_div_test.sv
`timescale 1ns/1ps
module kclk_div_test;
   localparam real CYC = 8.0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        clk_en;
   logic        busy;

   int checks = 0;
   int errors = 0;

   always #(CYC/2) clk = ~clk;

   kclk_div uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_en(clk_en), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      step();
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a; #1; d = bus_rdata;
   endtask

   function automatic logic [31:0] divw(input int d);
      return 32'h5A00_0000 | (32'(d) << 12);
   endfunction

   task automatic t_reset();
      logic [31:0] v;
      rd(3'd0, v); chk(v == 0, "R9 ctrl", v, 0);
      rd(3'd4, v); chk(v == 0, "R9 div", v, 0);
      chk(!busy && !clk_en, "R9 busy/clk_en", {busy, clk_en}, 0);
   endtask

   task automatic t_key();
      logic [31:0] v;
      wr(3'd4, 32'h0000_5000);
      rd(3'd4, v); chk(v == 0, "R1 div unkeyed", v, 0);
      wr(3'd4, divw(5));
      wr(3'd4, 32'h5B00_9000);
      rd(3'd4, v); chk(v == 32'h0000_5000, "R1 wrong key", v, 32'h5000);
      wr(3'd0, 32'h0000_0016);
      rd(3'd0, v); chk(v == 0, "R1 ctrl unkeyed", v, 0);
      repeat (8) step();
      chk(!busy, "R1 no start", busy, 0);
   endtask

   task automatic t_fields();
      logic [31:0] v;
      wr(3'd0, 32'h5A00_00E6);
      rd(3'd0, v); chk(v == 32'h06, "R2 ro bits", v, 32'h06);
      chk(!busy, "R2 busy unaffected", busy, 0);
      wr(3'd0, 32'h5A00_0000);
      wr(3'd4, 32'h5AFF_FFFF);
      rd(3'd4, v); chk(v == 32'h00FF_F000, "R3 div field", v, 32'h00FF_F000);
      wr(3'd4, 32'h5A00_0000);
   endtask

   task automatic t_no_start();
      int seen;
      wr(3'd4, divw(3));
      wr(3'd0, 32'h5A00_0016);
      seen = 0;
      for (int i = 0; i < 12; i++) begin seen += busy + clk_en; step(); end
      chk(seen == 0, "R5 div 3", seen, 0);
      wr(3'd0, 32'h5A00_0000);
      wr(3'd4, divw(8));
      wr(3'd0, 32'h5A00_0015);
      seen = 0;
      for (int i = 0; i < 20; i++) begin seen += busy + clk_en; step(); end
      chk(seen == 0, "R5 src 5", seen, 0);
      wr(3'd0, 32'h5A00_0000);
   endtask

   task automatic t_run(input int d);
      int bad;
      wr(3'd4, divw(d));
      wr(3'd0, 32'h5A00_0016);
      chk(!busy, "R4 busy low after write", busy, 0);
      step();
      chk(busy, "R4 busy high next cycle", busy, 1);
      bad = 0;
      for (int i = 0; i < 2 * d; i++) begin
         if (clk_en != ((i % d) == d - 1)) bad++;
         step();
      end
      chk(bad == 0, $sformatf("R6 tick pattern div %0d", d), bad, 0);
   endtask

   task automatic t_stop(input int d);
      int n;
      logic prev;
      int late;
      wr(3'd0, 32'h5A00_0006);
      n = 0; prev = 1'b0;
      while (busy && n < d + 3) begin prev = clk_en; step(); n++; end
      chk(!busy && prev && n <= d, $sformatf("R7 stop div %0d", d), {prev, 7'(n)}, {1'b1, 7'(d)});
      late = 0;
      for (int i = 0; i < d + 2; i++) begin late += clk_en + busy; step(); end
      chk(late == 0, "R7 quiet after stop", late, 0);
   endtask

   task automatic t_lock();
      logic [31:0] v;
      wr(3'd4, divw(6));
      wr(3'd0, 32'h5A00_0016);
      step();
      wr(3'd4, divw(9));
      rd(3'd4, v); chk(v == 32'h0000_6000, "R8 div frozen", v, 32'h6000);
      wr(3'd0, 32'h5A00_0013);
      rd(3'd0, v); chk(v == 32'h96, "R8 src frozen", v, 32'h96);
      wr(3'd0, 32'h5A00_0003);
      rd(3'd0, v); chk(v[6:0] == 7'h06, "R8 enable still writable", v, 32'h06);
      for (int i = 0; i < 10 && busy; i++) step();
      wr(3'd0, 32'h5A00_0003);
      rd(3'd0, v); chk(v == 32'h03, "R8 src after stop", v, 32'h03);
      wr(3'd0, 32'h5A00_0000);
   endtask

   initial begin
      #(CYC * 150000);
      checks++; errors++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();
      t_reset();
      t_key();
      t_fields();
      t_no_start();
      t_run(4);    t_stop(4);
      t_run(9);    t_stop(9);
      t_run(4095); t_stop(4095);
      t_lock();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule